// File: doc/BRIEF.md
# External Edge Port Interrupt Unit

This peripheral watches seven active-low external interrupt pins, numbered 1 to 7, and drives one interrupt request per pin toward a downstream interrupt controller. Position 0 exists in every register but is reserved: it stores nothing and never raises a request. Each pin passes through a two-flop synchronizer. A per-pin sensing mode then selects either level sensing or detection of rising, falling or both edges.

Software reaches four registers over a simple synchronous bus. The first holds the sensing modes. The others hold the pin directions, the interrupt enables and the event flags. Reads are combinational from the address, and writes take effect at the clock edge that samples them. In the edge modes a flag is sticky and is cleared by writing 1 to its bit. In level mode the flag mirrors the pin, low meaning active. A pin's request is its flag, qualified by its enable bit and by the pin being configured as an input.

Top module: `ext_edge_irq`

## Requirements
- R1: After reset every register reads zero and every interrupt request is low, which means all pins are level-sensitive inputs with interrupts disabled.
- R2: Registers are selected by `bus_addr`: 0 is the 16-bit mode register, 1 is direction, 2 is enable and 3 is the flag register, with the 8-bit registers zero-extended on reads. A write to the mode, direction or enable register reads back unchanged, except that the position 0 bits (mode bits 1:0, bit 0 elsewhere) always read 0. This lets software update one pin's field by read-modify-write without disturbing the others.
- R3: A pin change reaches its flag and its request after exactly three rising clock edges: two synchronizer stages and then the flag register.
- R4: Pin n's mode sits in mode register bits [2n+1:2n]. With the value 00 (level), the flag equals the inverted synchronized pin, so a low pin is active. The flag is not sticky and ignores write-1 clears.
- R5: Mode 01 sets the flag on a synchronized low-to-high transition of the pin. The flag then stays set while the pin is static.
- R6: Mode 10 sets the flag on a synchronized high-to-low transition. A rising transition does not set it.
- R7: Mode 11 sets the flag on transitions in either direction.
- R8: In the edge modes, writing 1 to a flag bit at address 3 clears that flag and writing 0 leaves it unchanged. An edge that is detected in the same cycle as the clear wins.
- R9: Pin n's request is high exactly when flag n is 1, enable n is 1 and direction n is 0 (input). A direction bit of 1 masks the request but keeps the flag.
- R10: Position 0 never sets a flag or raises a request, whatever the mode, enable or pin 0 activity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| pin_in | input | 8 | External pins, asynchronous, bit 0 unused |
| irq_out | output | 8 | Interrupt requests, one per pin |

## Verification
Register writes show on `bus_rdata` after the edge that samples them. Reads are valid in the same cycle the address is driven. Flags and requests follow a pin change on the third rising edge, and a flag clear or a gating change acts on the first edge. The bench drives every input on the falling edge and steps a reference model once per rising edge, using the values it drove. It compares requests and a register readback at the next falling edge, so each expectation is sampled in the cycle its result is due. A directed case counts the three-edge pin latency explicitly.

// File: rtl/ext_edge_irq.sv
module ext_edge_irq #(
  parameter int PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [1:0]          bus_addr,
  input  logic [2*PINS-1:0]   bus_wdata,
  output logic [2*PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]     pin_in,
  output logic [PINS-1:0]     irq_out
);
  localparam int MW = 2 * PINS;
  localparam logic [PINS-1:0] LIVE = {{(PINS-1){1'b1}}, 1'b0};
  localparam logic [MW-1:0]   MLIVE = {{(MW-2){1'b1}}, 2'b00};

  logic [PINS-1:0] sync1, sync2, prev;
  logic [MW-1:0]   mode_q;
  logic [PINS-1:0] dir_q, en_q, flag_q, flag_n, clr;
  logic            wr_en;

  assign wr_en = bus_sel & bus_wr;
  assign clr   = (wr_en && bus_addr == 2'd3) ? bus_wdata[PINS-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '1;
      sync2 <= '1;
      prev  <= '1;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      prev  <= sync2;
    end

  always_comb
    for (int i = 0; i < PINS; i++) begin
      if (!mode_q[2*i] && !mode_q[2*i+1])
        flag_n[i] = ~sync2[i];
      else
        flag_n[i] = (flag_q[i] & ~clr[i])
                  | (mode_q[2*i]   &  sync2[i] & ~prev[i])
                  | (mode_q[2*i+1] & ~sync2[i] &  prev[i]);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_q <= '0;
      dir_q  <= '0;
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      flag_q <= flag_n & LIVE;
      if (wr_en) begin
        if (bus_addr == 2'd0) mode_q <= bus_wdata & MLIVE;
        if (bus_addr == 2'd1) dir_q  <= bus_wdata[PINS-1:0] & LIVE;
        if (bus_addr == 2'd2) en_q   <= bus_wdata[PINS-1:0] & LIVE;
      end
    end

  always_comb
    case (bus_addr)
      2'd0:    bus_rdata = mode_q;
      2'd1:    bus_rdata = {{(MW-PINS){1'b0}}, dir_q};
      2'd2:    bus_rdata = {{(MW-PINS){1'b0}}, en_q};
      default: bus_rdata = {{(MW-PINS){1'b0}}, flag_q};
    endcase

  assign irq_out = flag_q & en_q & ~dir_q;
endmodule

// File: rtl/ext_edge_irq_chk.sv
module ext_edge_irq_chk #(
  parameter int PINS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_sel,
  input logic                bus_wr,
  input logic [1:0]          bus_addr,
  input logic [PINS-1:0]     clr_data,
  input logic [2*PINS-1:0]   mode,
  input logic [PINS-1:0]     s2,
  input logic [PINS-1:0]     s3,
  input logic [PINS-1:0]     flag,
  input logic [PINS-1:0]     irq
);
  localparam logic [PINS-1:0] LIVE = {{(PINS-1){1'b1}}, 1'b0};

  logic [PINS-1:0] rise_m, fall_m, lvl_m, clr_v;

  always_comb
    for (int i = 0; i < PINS; i++) begin
      rise_m[i] = mode[2*i];
      fall_m[i] = mode[2*i+1];
      lvl_m[i]  = ~(mode[2*i] | mode[2*i+1]);
    end

  assign clr_v = (bus_sel && bus_wr && bus_addr == 2'd3) ? clr_data : '0;

  p_level_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag ^ ~$past(s2)) & $past(lvl_m) & LIVE) == '0);

  p_rise_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(s2 & ~s3 & rise_m) & LIVE & ~flag) == '0);

  p_fall_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(~s2 & s3 & fall_m) & LIVE & ~flag) == '0);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flag & ~lvl_m & ~clr_v) & ~flag) == '0);

  p_slot0_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !flag[0] && !irq[0]);
endmodule

bind ext_edge_irq ext_edge_irq_chk #(.PINS(PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .clr_data(bus_wdata[PINS-1:0]), .mode(mode_q),
  .s2(sync2), .s3(prev), .flag(flag_q), .irq(irq_out)
);

// File: tb/test_ext_edge_irq.sv
module test_ext_edge_irq;
  localparam int PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [1:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic [7:0]  pin_in = 8'hFF, irq_out;

  int checks = 0, failures = 0;
  logic [7:0]  m_s1 = 8'hFF, m_s2 = 8'hFF, m_s3 = 8'hFF;
  logic [7:0]  m_flag = 0, m_dir = 0, m_en = 0;
  logic [15:0] m_mode = 0;

  ext_edge_irq i_ext_edge_irq (.*);

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [7:0] exp_irq();
    return m_flag & m_en & ~m_dir;
  endfunction

  function automatic logic [15:0] exp_reg(input logic [1:0] a);
    case (a)
      2'd0: return m_mode;
      2'd1: return {8'h0, m_dir};
      2'd2: return {8'h0, m_en};
      default: return {8'h0, m_flag};
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] p, input logic s, input logic w,
                      input logic [1:0] a, input logic [15:0] wd);
    logic [7:0] clr, nf;
    pin_in = p; bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = wd;
    @(posedge clk);
    clr = (s && w && a == 2'd3) ? wd[7:0] : 8'h0;
    nf = 0;
    for (int i = 1; i < 8; i++) begin
      if (!m_mode[2*i] && !m_mode[2*i+1]) nf[i] = ~m_s2[i];
      else nf[i] = (m_flag[i] & ~clr[i]) | (m_mode[2*i] & m_s2[i] & ~m_s3[i])
                 | (m_mode[2*i+1] & ~m_s2[i] & m_s3[i]);
    end
    m_flag = nf;
    if (s && w) begin
      if (a == 2'd0) m_mode = wd & 16'hFFFC;
      if (a == 2'd1) m_dir = wd[7:0] & 8'hFE;
      if (a == 2'd2) m_en = wd[7:0] & 8'hFE;
    end
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = p;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    step(pin_in, 1'b1, 1'b1, a, d);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(pin_in, 1'b0, 1'b0, 2'd0, 16'h0);
  endtask

  task automatic rd(input string req, input logic [1:0] a);
    bus_sel = 0; bus_wr = 0; bus_addr = a;
    #1;
    chk(req, bus_rdata, exp_reg(a));
  endtask

  initial begin
    #(PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      bus_addr = a[1:0]; #1;
      chk("R1", bus_rdata, 16'h0);
    end
    chk("R1 irq", {8'h0, irq_out}, 16'h0);
    // R2 readback with reserved slot
    wr(2'd0, 16'hFFFF); rd("R2", 2'd0); chk("R2 mode", bus_rdata, 16'hFFFC);
    wr(2'd1, 16'h00FF); rd("R2", 2'd1); chk("R2 dir", bus_rdata, 16'h00FE);
    wr(2'd2, 16'h00A5); rd("R2", 2'd2); chk("R2 en", bus_rdata, 16'h00A4);
    wr(2'd0, 16'h0000); wr(2'd1, 16'h0000); wr(2'd2, 16'h00FE);
    idle(4);
    // R3 latency and R4 level sensing (pin 3)
    step(8'hF7, 0, 0, 0, 0); chk("R3 edge1", {15'h0, irq_out[3]}, 16'h0);
    step(8'hF7, 0, 0, 0, 0); chk("R3 edge2", {15'h0, irq_out[3]}, 16'h0);
    step(8'hF7, 0, 0, 0, 0); chk("R3 edge3", {15'h0, irq_out[3]}, 16'h1);
    wr(2'd3, 16'h00FF); idle(1); chk("R4 no clear", {15'h0, irq_out[3]}, 16'h1);
    pin_in = 8'hFF; idle(3); chk("R4 follows", {15'h0, irq_out[3]}, 16'h0);
    // R5 rising on pin 2
    wr(2'd0, 16'h0010);
    pin_in = 8'hFB; idle(4); rd("R5 fall ignored", 2'd3);
    chk("R5 no set", {15'h0, bus_rdata[2]}, 16'h0);
    pin_in = 8'hFF; idle(4); rd("R5", 2'd3);
    chk("R5 set", {15'h0, bus_rdata[2]}, 16'h1);
    // R8 clear semantics
    wr(2'd3, 16'h00FB); rd("R8 zero keeps", 2'd3);
    chk("R8 kept", {15'h0, bus_rdata[2]}, 16'h1);
    wr(2'd3, 16'h0004); rd("R8 cleared", 2'd3);
    chk("R8 clr", {15'h0, bus_rdata[2]}, 16'h0);
    // R6 falling on pin 5
    wr(2'd0, 16'h0800);
    pin_in = 8'hDF; idle(4); chk("R6 set", {15'h0, irq_out[5]}, 16'h1);
    wr(2'd3, 16'h0020); pin_in = 8'hFF; idle(4);
    chk("R6 rise ignored", {15'h0, irq_out[5]}, 16'h0);
    // R7 both on pin 7
    wr(2'd0, 16'hC000);
    pin_in = 8'h7F; idle(4); chk("R7 fall", {15'h0, irq_out[7]}, 16'h1);
    wr(2'd3, 16'h0080); idle(1); chk("R7 cleared", {15'h0, irq_out[7]}, 16'h0);
    pin_in = 8'hFF; idle(4); chk("R7 rise", {15'h0, irq_out[7]}, 16'h1);
    // R9 direction masks request, flag kept
    wr(2'd1, 16'h0080); chk("R9 masked", {8'h0, irq_out}, {8'h0, exp_irq()});
    rd("R9 flag kept", 2'd3);
    wr(2'd1, 16'h0000); chk("R9 unmasked", {15'h0, irq_out[7]}, 16'h1);
    // R10 slot 0
    wr(2'd0, 16'hFFFF); wr(2'd2, 16'h00FF);
    for (int k = 0; k < 8; k++) step({7'h7F, k[0]}, 0, 0, 0, 0);
    rd("R10 flag", 2'd3); chk("R10 bit0", {15'h0, bus_rdata[0]}, 16'h0);
    chk("R10 irq0", {15'h0, irq_out[0]}, 16'h0);
    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] p;
      logic s;
      p = pin_in;
      if ($urandom_range(0, 3) == 0) p[$urandom_range(0, 7)] ^= 1'b1;
      s = ($urandom_range(0, 5) == 0);
      step(p, s, s, 2'($urandom_range(0, 3)), 16'($urandom));
      chk("R9 random", {8'h0, irq_out}, {8'h0, exp_irq()});
      rd("R2 random", 2'($urandom_range(0, 3)));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule